// File: doc/BRIEF.md
# Receive Byte Queue with Fill Threshold

This block sits on the receive side of a two-wire serial controller. It lies between the byte shift register, which delivers one assembled byte per strobe, and the register read port that software or a DMA engine uses to collect those bytes. Bytes are held in first-in first-out order. When the fill level reaches a programmed threshold, the block raises a ready indication. Software can poll that indication, take it as an interrupt, or have it forwarded as a DMA request.

A transfer may end with a final group that is smaller than the threshold. In that case an end-of-transfer pulse sets a sticky drain flag, so the tail bytes can still be collected. The block never drops a byte. If a byte arrives while the queue is full, the byte is parked in a one-entry holding slot that stands for the occupied shift register, and the block holds the serial clock low until a read frees space. A read of an empty queue returns zero, leaves the queue unchanged and sets an access-error flag. The drain, overrun and access-error flags are write-one-to-clear.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the queue is empty, every `rx_stat` bit is 0, and `irq`, `dma_req`, `scl_hold` and `rd_data` are 0.
- R2: Bytes are read back in arrival order. While the queue is not empty, `rd_data` shows the oldest byte, and a cycle with `rd_en` high removes it at the clock edge.
- R3: `rx_stat[0]` (ready) is 1 exactly when the occupancy is at least `thr_cfg` + 1, so a field value of 0 means one byte and 63 means 64 bytes.
- R4: On an `xfer_end` cycle, `rx_stat[1]` (drain) is set from the next cycle if the occupancy after that edge, counting a byte accepted at the same edge, lies between 1 and `thr_cfg`. It is left unchanged otherwise, including when the queue is empty.
- R5: A byte that arrives while the queue holds 64 bytes, with no read in the same cycle, is kept in a holding slot. From the next cycle `rx_stat[2]` (overrun) is set and `scl_hold` is 1. Further strobes are ignored while the slot is occupied.
- R6: A read while `scl_hold` is 1 moves the held byte into the queue at the same edge, and `scl_hold` returns to 0 in the next cycle. No byte is lost or reordered.
- R7: A read of an empty queue gives `rd_data` = 0, moves no pointer, and sets `rx_stat[3]` (access error) from the next cycle.
- R8: A 1 in `stat_clr` bit 1, 2 or 3 clears the matching sticky flag. A new event in the same cycle wins over the clear. `stat_clr[0]` has no effect.
- R9: `dma_req` equals `dma_en` AND ready. While `dma_en` is 1, the ready condition does not contribute to `irq`.
- R10: `irq` is the OR of ready AND `ready_ie` (when `dma_en` is 0), drain AND `drain_ie`, and access error AND `aerr_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | One-cycle strobe: a byte from the shifter is present |
| byte_data | input | DATA_W | Received byte |
| xfer_end | input | 1 | One-cycle pulse at the end of a receive transfer |
| rd_en | input | 1 | Register read of the data port this cycle |
| rd_data | output | DATA_W | Oldest byte, or 0 when the queue is empty |
| thr_cfg | input | THR_W | Threshold field; effective threshold is value + 1 |
| ready_ie | input | 1 | Interrupt enable for ready |
| drain_ie | input | 1 | Interrupt enable for drain |
| aerr_ie | input | 1 | Interrupt enable for access error |
| dma_en | input | 1 | Route ready to `dma_req` instead of `irq` |
| stat_clr | input | 4 | Write-one-to-clear strobes, aligned with `rx_stat` |
| rx_stat | output | 4 | {access error, overrun, drain, ready} |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 1 | DMA request for the receive channel |
| scl_hold | output | 1 | Hold the serial clock low (queue and shifter full) |

## Verification
The bound checker watches several rules on every cycle. Occupancy never exceeds the depth. A rising clock hold is always accompanied by the overrun flag. Any read during a hold releases it on the following cycle. An empty read returns zero and raises the access error. The DMA request only appears when it is enabled and ready is true. A clear of the drain flag takes effect unless a drain event arrives in the same cycle.

Only the bench scenarios show the rest. These are byte ordering across the overrun and release, the exact threshold edges for field values 0, 3 and 63, and the drain decision when the last byte and `xfer_end` share a cycle. They also cover the pointers staying put after an empty read, and the routing of ready between `irq` and `dma_req`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Positions inside the status vector; software clears with the same layout.
    localparam int unsigned STAT_READY = 0;
    localparam int unsigned STAT_DRAIN = 1;
    localparam int unsigned STAT_OVR   = 2;
    localparam int unsigned STAT_AERR  = 3;
    localparam int unsigned STAT_W     = 4;

    typedef struct packed {
        logic aerr;
        logic ovr;
        logic drain;
    } rxq_flags_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rd_en,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [AW-1:0]     raddr,
    output logic [CW-1:0]     occ,
    output logic [CW-1:0]     occ_nxt,
    output logic              empty,
    output logic              hold,
    output logic              ovr_evt,
    output logic              aerr_evt
);

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     cnt;
        logic              pend;
        logic [DATA_W-1:0] pdata;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  full, pop, room, push;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        step = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        empty    = (st_q.cnt == '0);
        full     = (st_q.cnt == CW'(DEPTH));
        pop      = rd_en && !empty;
        room     = !full || pop;
        push     = 1'b0;
        wdata    = byte_data;
        ovr_evt  = 1'b0;
        aerr_evt = rd_en && empty;

        if (st_q.pend) begin
            // shifter is stalled; only a freed slot lets the parked byte in
            wdata = st_q.pdata;
            if (room) begin
                push      = 1'b1;
                st_d.pend = 1'b0;
            end
        end else if (byte_vld) begin
            if (room) begin
                push = 1'b1;
            end else begin
                st_d.pend  = 1'b1;
                st_d.pdata = byte_data;
                ovr_evt    = 1'b1;
            end
        end

        if (push) begin
            st_d.wptr = step(st_q.wptr);
        end
        if (pop) begin
            st_d.rptr = step(st_q.rptr);
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we      = push;
    assign waddr   = st_q.wptr;
    assign raddr   = st_q.rptr;
    assign occ     = st_q.cnt;
    assign occ_nxt = st_d.cnt;
    assign hold    = st_q.pend;

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drain_evt,
    input  logic              ovr_evt,
    input  logic              aerr_evt,
    input  logic [STAT_W-1:0] clr,
    output rxq_flags_t        flags
);

    rxq_flags_t flg_q, flg_d;

    always_comb begin
        flg_d = flg_q;
        if (clr[STAT_DRAIN]) flg_d.drain = 1'b0;
        if (clr[STAT_OVR])   flg_d.ovr   = 1'b0;
        if (clr[STAT_AERR])  flg_d.aerr  = 1'b0;
        // events override a clear in the same cycle
        if (drain_evt) flg_d.drain = 1'b1;
        if (ovr_evt)   flg_d.ovr   = 1'b1;
        if (aerr_evt)  flg_d.aerr  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign flags = flg_q;

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned THR_W  = 6,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              xfer_end,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [THR_W-1:0]  thr_cfg,
    input  logic              ready_ie,
    input  logic              drain_ie,
    input  logic              aerr_ie,
    input  logic              dma_en,
    input  logic [3:0]        stat_clr,
    output logic [3:0]        rx_stat,
    output logic              irq,
    output logic              dma_req,
    output logic              scl_hold
);

    logic              we, empty, ovr_evt, aerr_evt, drain_evt, ready;
    logic [AW-1:0]     waddr, raddr;
    logic [DATA_W-1:0] wdata, rdata;
    logic [CW-1:0]     occ, occ_nxt, thr_eff;
    rxq_flags_t        flags;

    rxq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .rd_en     (rd_en),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr     (raddr),
        .occ       (occ),
        .occ_nxt   (occ_nxt),
        .empty     (empty),
        .hold      (scl_hold),
        .ovr_evt   (ovr_evt),
        .aerr_evt  (aerr_evt)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    // effective threshold is the field plus one
    assign thr_eff   = CW'(thr_cfg) + CW'(1);
    assign ready     = (occ >= thr_eff);
    assign drain_evt = xfer_end && (occ_nxt != '0) && (occ_nxt < thr_eff);

    rxq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .drain_evt (drain_evt),
        .ovr_evt   (ovr_evt),
        .aerr_evt  (aerr_evt),
        .clr       (stat_clr),
        .flags     (flags)
    );

    assign rd_data = empty ? '0 : rdata;
    assign rx_stat = {flags.aerr, flags.ovr, flags.drain, ready};
    assign dma_req = dma_en && ready;
    assign irq     = (ready && ready_ie && !dma_en)
                   || (flags.drain && drain_ie)
                   || (flags.aerr && aerr_ie);

endmodule

// File: rtl/rx_byte_queue_chk.sv
module rx_byte_queue_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [3:0]        rx_stat,
    input logic [3:0]        stat_clr,
    input logic              dma_en,
    input logic              dma_req,
    input logic              scl_hold,
    input logic [CW-1:0]     occ,
    input logic              drain_evt
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R5

    AST_HOLD_FLAGS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> rx_stat[2]); // R5

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold && rd_en) |=> !scl_hold); // R6

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && occ == '0) |-> (rd_data == '0)); // R7

    AST_AERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && occ == '0) |=> rx_stat[3]); // R7

    AST_DRAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr[1] && !drain_evt) |=> !rx_stat[1]); // R8

    AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (dma_en && rx_stat[0])); // R9

endmodule

bind rx_byte_queue rx_byte_queue_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rx_stat   (rx_stat),
    .stat_clr  (stat_clr),
    .dma_en    (dma_en),
    .dma_req   (dma_req),
    .scl_hold  (scl_hold),
    .occ       (occ),
    .drain_evt (drain_evt)
);

// File: tb/test_rx_byte_queue.sv
module test_rx_byte_queue;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       xfer_end = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [5:0] thr_cfg = '0;
    logic       ready_ie = 1'b0;
    logic       drain_ie = 1'b0;
    logic       aerr_ie = 1'b0;
    logic       dma_en = 1'b0;
    logic [3:0] stat_clr = '0;
    logic [3:0] rx_stat;
    logic       irq, dma_req, scl_hold;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    rx_byte_queue i_rx_byte_queue (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .xfer_end(xfer_end), .rd_en(rd_en), .rd_data(rd_data), .thr_cfg(thr_cfg),
        .ready_ie(ready_ie), .drain_ie(drain_ie), .aerr_ie(aerr_ie), .dma_en(dma_en),
        .stat_clr(stat_clr), .rx_stat(rx_stat), .irq(irq), .dma_req(dma_req),
        .scl_hold(scl_hold)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: offers one byte, records it in the scoreboard
    task automatic push(input logic [7:0] b, input logic last);
        byte_vld  = 1'b1;
        byte_data = b;
        xfer_end  = last;
        exp_q.push_back(b);
        @(negedge clk);
        byte_vld = 1'b0;
        xfer_end = 1'b0;
    endtask

    // monitor side: compares the oldest byte against the scoreboard
    task automatic pop_chk(input string req);
        logic [7:0] e;
        e = exp_q.pop_front();
        rd_en = 1'b1;
        #1 check(req, rd_data, e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_empty();
        rd_en = 1'b1;
        #1 check("R7 empty data", rd_data, 8'h00);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear(input logic [3:0] bits);
        stat_clr = bits;
        @(negedge clk);
        stat_clr = '0;
    endtask

    task automatic pulse_end();
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 stat", rx_stat, 4'h0);
        check("R1 irq", irq, 1'b0);
        check("R1 dma", dma_req, 1'b0);
        check("R1 hold", scl_hold, 1'b0);
        check("R1 data", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // threshold 4 bytes
        thr_cfg = 6'd3;
        ready_ie = 1'b1;
        for (int i = 0; i < 3; i++) push(8'h10 + 8'(i), 1'b0);
        check("R3 below", rx_stat[0], 1'b0);
        check("R10 irq idle", irq, 1'b0);
        push(8'h13, 1'b0);
        check("R3 at thr", rx_stat[0], 1'b1);
        check("R10 ready irq", irq, 1'b1);
        for (int i = 0; i < 4; i++) pop_chk("R2 order");
        check("R3 drained", rx_stat[0], 1'b0);
        ready_ie = 1'b0;

        pulse_end();
        check("R4 empty end", rx_stat[1], 1'b0);

        // short tail, last byte and end in the same cycle
        drain_ie = 1'b1;
        push(8'h21, 1'b0);
        push(8'h22, 1'b1);
        check("R4 drain set", rx_stat[1], 1'b1);
        check("R10 drain irq", irq, 1'b1);
        clear(4'b0010);
        check("R8 drain clr", rx_stat[1], 1'b0);
        drain_ie = 1'b0;
        pop_chk("R2 tail");
        pop_chk("R2 tail");

        // empty read
        aerr_ie = 1'b1;
        read_empty();
        check("R7 aerr", rx_stat[3], 1'b1);
        check("R10 aerr irq", irq, 1'b1);
        push(8'h5C, 1'b0);
        pop_chk("R7 ptr kept");
        stat_clr = 4'b1000;
        rd_en = 1'b1;
        @(negedge clk);
        stat_clr = '0;
        rd_en = 1'b0;
        check("R8 set wins", rx_stat[3], 1'b1);
        clear(4'b1000);
        check("R8 aerr clr", rx_stat[3], 1'b0);
        aerr_ie = 1'b0;

        // DMA routing, threshold 1 byte
        thr_cfg = 6'd0;
        dma_en = 1'b1;
        ready_ie = 1'b1;
        push(8'h77, 1'b0);
        check("R9 dma req", dma_req, 1'b1);
        check("R9 irq masked", irq, 1'b0);
        clear(4'b0001);
        check("R8 bit0 none", rx_stat[0], 1'b1);
        pop_chk("R2 dma");
        check("R9 dma off", dma_req, 1'b0);
        dma_en = 1'b0;
        ready_ie = 1'b0;

        // full queue and overrun
        thr_cfg = 6'd63;
        for (int i = 0; i < 63; i++) push(8'(i) ^ 8'hA5, 1'b0);
        check("R3 63 below", rx_stat[0], 1'b0);
        push(8'hE0, 1'b0);
        check("R3 64 ready", rx_stat[0], 1'b1);
        check("R5 no hold", scl_hold, 1'b0);
        push(8'hE1, 1'b0);
        check("R5 hold", scl_hold, 1'b1);
        check("R5 ovr", rx_stat[2], 1'b1);
        byte_vld = 1'b1;
        byte_data = 8'hEE;
        @(negedge clk);
        byte_vld = 1'b0;
        check("R5 still hold", scl_hold, 1'b1);
        pop_chk("R6 first");
        check("R6 release", scl_hold, 1'b0);
        check("R6 still full", rx_stat[0], 1'b1);
        for (int i = 0; i < 64; i++) pop_chk("R6 order");
        check("R6 empty", rd_data, 8'h00);
        clear(4'b0100);
        check("R8 ovr clr", rx_stat[2], 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule